// File: doc/BRIEF.md
# I2C Slave Word Register Port

This block is an I2C target that exposes a bank of 16-bit registers through an 8-bit word pointer. It oversamples the bus lines on the system clock and finds START and STOP conditions from SDA edges while SCL is high. It drives SDA only by pulling it low. Toward the chip it offers a simple register-file port: an address that always equals the word pointer, a write word with a one-cycle write strobe, and a read word that the register file returns combinationally for the current address.

A bus write carries the device byte, a pointer byte, then the data word as its high byte followed by its low byte. A read sends words from the pointer, high byte first. Reads take one of two forms. A current-address read reads from wherever the pointer already stands. A random read first sends a device byte and pointer byte with no data, then a repeated START and a read. The pointer steps by one for each complete word moved, not for each byte. The device byte always has its top address bit set, and the other six address bits come from a strap input.

Top module: `i2c_word_slave`

## Requirements
- R1: A device byte is accepted only when its upper seven bits equal {1, dev_sel}. An accepted byte is acknowledged with SDA low during the ninth clock. A rejected byte gets no acknowledge, and after it SDA stays released, no write strobe fires and the pointer does not change until the next START.
- R2: After reset the pointer (reg_addr) is 0, sda_oe is 0 and reg_we is 0.
- R3: A write sequence (START, device byte with bit 0 = 0, pointer byte, high data byte, low data byte) has all four bytes acknowledged. Exactly one single-cycle reg_we pulse follows the low byte's acknowledge clock, with reg_addr equal to the pointer byte and reg_wdata equal to {high byte, low byte}.
- R4: A write cut off by STOP after the high data byte fires no write strobe and leaves that register unchanged, but the pointer byte it carried is still loaded.
- R5: The pointer increases by one, modulo 256, after each complete word: in the cycle after reg_we for a write, and after the low byte's acknowledge clock for a read. At no other time does it change, except when a pointer byte loads it.
- R6: A read with no preceding pointer byte (device byte bit 0 = 1) returns the register at the current pointer. Directly after reset that register is 0.
- R7: A random read (device and pointer byte, repeated START, device byte with bit 0 = 1) returns the register at the given pointer and fires no write strobe.
- R8: Each word is sent high byte first, most significant bit first. The low byte is sent only if the master acknowledged the high byte. A NACK after the high byte ends the read and leaves the pointer unchanged.
- R9: When the master acknowledges a low byte, the next word sent is the register at the incremented pointer, so a long read streams consecutive registers.
- R10: A START or STOP at any point releases SDA and restarts byte framing. A START inside a write discards the partial word, and the transfer that follows it is handled in full.
- R11: A word completed with the pointer at 0xFF wraps the pointer to 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| dev_sel | input | 6 | Lower six bits of the device address |
| reg_addr | output | 8 | Word pointer, used as register address |
| reg_wdata | output | 16 | Word to write |
| reg_we | output | 1 | One-cycle write strobe |
| reg_rdata | input | 16 | Register contents at reg_addr |

## Verification
A pointer that is wrong by even one step reaches the ports at once on reg_addr. It also shows on the bus within one word, because the next read returns a neighbouring register's value. If the bit counter or field tracking slips, the acknowledge lands in the wrong clock or is missing. The master's acknowledge sample sees this within nine SCL periods. A write strobe that fires at the wrong time shows as an extra, missing or misaddressed update of the bench's register model, in the cycle the strobe is raised.

// File: rtl/i2c_word_pkg.sv
package i2c_word_pkg;

    localparam int BYTE_W = 8;
    localparam int WORD_W = 2 * BYTE_W;
    localparam int PTR_W  = 8;
    localparam int SEL_W  = 6;
    localparam int CNT_W  = $clog2(BYTE_W + 1);

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_RX,
        PH_RX_ACK,
        PH_TX_WAIT,
        PH_TX_LOAD,
        PH_TX,
        PH_TX_ACK
    } phase_e;

    typedef enum logic [1:0] {
        FLD_DEV,
        FLD_PTR,
        FLD_MSB,
        FLD_LSB
    } field_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
        logic sda;
    } line_ev_t;

    function automatic logic dev_hit(input logic [BYTE_W-1:0] b,
                                     input logic [SEL_W-1:0] sel);
        return b[BYTE_W-1:1] == {1'b1, sel};
    endfunction

endpackage

// File: rtl/i2c_line_cond.sv
module i2c_line_cond
    import i2c_word_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_i,
    input  logic     sda_i,
    output line_ev_t ev
);
    logic [STAGES-1:0] scl_sh, sda_sh;
    logic scl_q, sda_q, scl_n, sda_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_sh <= '1;
            sda_sh <= '1;
            scl_q  <= 1'b1;
            sda_q  <= 1'b1;
        end else begin
            scl_sh <= {scl_sh[STAGES-2:0], scl_i};
            sda_sh <= {sda_sh[STAGES-2:0], sda_i};
            scl_q  <= scl_sh[STAGES-1];
            sda_q  <= sda_sh[STAGES-1];
        end
    end

    assign scl_n = scl_sh[STAGES-1];
    assign sda_n = sda_sh[STAGES-1];

    always_comb begin
        ev.rise  = scl_n & ~scl_q;
        ev.fall  = ~scl_n & scl_q;
        ev.start = scl_n & scl_q & sda_q & ~sda_n;
        ev.stop  = scl_n & scl_q & ~sda_q & sda_n;
        ev.sda   = sda_n;
    end
endmodule

// File: rtl/i2c_word_engine.sv
module i2c_word_engine
    import i2c_word_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  line_ev_t          ev,
    input  logic [SEL_W-1:0]  dev_sel,
    input  logic [WORD_W-1:0] rd_word,
    output logic              sda_oe,
    output logic              ptr_load,
    output logic [PTR_W-1:0]  ptr_val,
    output logic              ptr_step,
    output logic              wr_fire,
    output logic [WORD_W-1:0] wr_word
);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

    phase_e             phase;
    field_e             field;
    logic [CNT_W-1:0]   cnt;
    logic [BYTE_W-1:0]  shreg;
    logic [BYTE_W-1:0]  msb_hold;
    logic [WORD_W-1:0]  tx_word;
    logic               rw;
    logic               hi;
    logic               mack;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_IDLE;
            field    <= FLD_DEV;
            cnt      <= '0;
            shreg    <= '0;
            msb_hold <= '0;
            tx_word  <= '0;
            rw       <= 1'b0;
            hi       <= 1'b0;
            mack     <= 1'b0;
            ptr_load <= 1'b0;
            ptr_val  <= '0;
            ptr_step <= 1'b0;
            wr_fire  <= 1'b0;
            wr_word  <= '0;
        end else begin
            ptr_load <= 1'b0;
            ptr_step <= 1'b0;
            wr_fire  <= 1'b0;
            if (ev.start) begin
                phase <= PH_RX;
                field <= FLD_DEV;
                cnt   <= '0;
            end else if (ev.stop) begin
                phase <= PH_IDLE;
            end else begin
                unique case (phase)
                    PH_RX: begin
                        if (ev.rise && cnt != LAST_BIT) begin
                            shreg <= {shreg[BYTE_W-2:0], ev.sda};
                            cnt   <= cnt + 1'b1;
                        end else if (ev.fall && cnt == LAST_BIT) begin
                            if (field != FLD_DEV || dev_hit(shreg, dev_sel))
                                phase <= PH_RX_ACK;
                            else
                                phase <= PH_IDLE;
                            if (field == FLD_DEV)
                                rw <= shreg[0];
                        end
                    end
                    PH_RX_ACK: begin
                        if (ev.fall) begin
                            cnt <= '0;
                            unique case (field)
                                FLD_DEV: begin
                                    if (rw) begin
                                        phase <= PH_TX_LOAD;
                                    end else begin
                                        phase <= PH_RX;
                                        field <= FLD_PTR;
                                    end
                                end
                                FLD_PTR: begin
                                    ptr_load <= 1'b1;
                                    ptr_val  <= shreg;
                                    phase    <= PH_RX;
                                    field    <= FLD_MSB;
                                end
                                FLD_MSB: begin
                                    msb_hold <= shreg;
                                    phase    <= PH_RX;
                                    field    <= FLD_LSB;
                                end
                                FLD_LSB: begin
                                    wr_fire <= 1'b1;
                                    wr_word <= {msb_hold, shreg};
                                    phase   <= PH_IDLE;
                                end
                                default: phase <= PH_IDLE;
                            endcase
                        end
                    end
                    PH_TX_WAIT: phase <= PH_TX_LOAD;
                    PH_TX_LOAD: begin
                        tx_word <= rd_word;
                        hi      <= 1'b1;
                        cnt     <= '0;
                        phase   <= PH_TX;
                    end
                    PH_TX: begin
                        if (ev.rise) begin
                            cnt <= cnt + 1'b1;
                        end else if (ev.fall) begin
                            tx_word <= {tx_word[WORD_W-2:0], 1'b0};
                            if (cnt == LAST_BIT)
                                phase <= PH_TX_ACK;
                        end
                    end
                    PH_TX_ACK: begin
                        if (ev.rise) begin
                            mack <= ~ev.sda;
                        end else if (ev.fall) begin
                            cnt <= '0;
                            if (!hi)
                                ptr_step <= 1'b1;
                            if (mack && hi) begin
                                hi    <= 1'b0;
                                phase <= PH_TX;
                            end else if (mack) begin
                                phase <= PH_TX_WAIT;
                            end else begin
                                phase <= PH_IDLE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign sda_oe = (phase == PH_RX_ACK) | ((phase == PH_TX) & ~tx_word[WORD_W-1]);
endmodule

// File: rtl/i2c_word_ptr.sv
module i2c_word_ptr
    import i2c_word_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ptr_load,
    input  logic [PTR_W-1:0]  ptr_val,
    input  logic              ptr_step,
    input  logic              wr_fire,
    input  logic [WORD_W-1:0] wr_word,
    output logic [PTR_W-1:0]  reg_addr,
    output logic [WORD_W-1:0] reg_wdata,
    output logic              reg_we
);
    always_ff @(posedge clk) begin
        if (rst) begin
            reg_addr  <= '0;
            reg_wdata <= '0;
            reg_we    <= 1'b0;
        end else begin
            reg_we <= wr_fire;
            if (wr_fire)
                reg_wdata <= wr_word;
            if (ptr_load)
                reg_addr <= ptr_val;
            else if (reg_we || ptr_step)
                reg_addr <= reg_addr + 1'b1;
        end
    end
endmodule

// File: rtl/i2c_word_slave.sv
module i2c_word_slave
    import i2c_word_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    input  logic [SEL_W-1:0]  dev_sel,
    output logic [PTR_W-1:0]  reg_addr,
    output logic [WORD_W-1:0] reg_wdata,
    output logic              reg_we,
    input  logic [WORD_W-1:0] reg_rdata
);
    line_ev_t          line_ev;
    logic              line_start, line_stop;
    logic              eng_ptr_load, eng_ptr_step, eng_wr_fire;
    logic [PTR_W-1:0]  eng_ptr_val;
    logic [WORD_W-1:0] eng_wr_word;

    i2c_line_cond #(.STAGES(SYNC_STAGES)) u_line (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev    (line_ev)
    );

    assign line_start = line_ev.start;
    assign line_stop  = line_ev.stop;

    i2c_word_engine u_eng (
        .clk      (clk),
        .rst      (rst),
        .ev       (line_ev),
        .dev_sel  (dev_sel),
        .rd_word  (reg_rdata),
        .sda_oe   (sda_oe),
        .ptr_load (eng_ptr_load),
        .ptr_val  (eng_ptr_val),
        .ptr_step (eng_ptr_step),
        .wr_fire  (eng_wr_fire),
        .wr_word  (eng_wr_word)
    );

    i2c_word_ptr u_ptr (
        .clk       (clk),
        .rst       (rst),
        .ptr_load  (eng_ptr_load),
        .ptr_val   (eng_ptr_val),
        .ptr_step  (eng_ptr_step),
        .wr_fire   (eng_wr_fire),
        .wr_word   (eng_wr_word),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_we    (reg_we)
    );
endmodule

// File: rtl/i2c_word_slave_chk.sv
module i2c_word_slave_chk
    import i2c_word_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             sda_oe,
    input logic             reg_we,
    input logic [PTR_W-1:0] reg_addr,
    input logic             start_evt,
    input logic             stop_evt,
    input logic             ptr_load,
    input logic             ptr_step
);
    logic rst_d;

    always_ff @(posedge clk) begin
        rst_d <= rst;
        if (rst_d && !rst) begin
            AST_RESET_STATE: assert (reg_addr == '0 && !sda_oe && !reg_we) // R2
                else $error("pointer or outputs not cleared by reset");
        end
    end

    AST_WE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        reg_we |=> !reg_we) else $error("write strobe longer than one cycle"); // R3

    AST_PTR_AFTER_WRITE: assert property (@(posedge clk) disable iff (rst)
        reg_we |=> reg_addr == $past(reg_addr) + 1'b1) else $error("pointer did not step after write"); // R5

    AST_PTR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!reg_we && !ptr_load && !ptr_step) |=> $stable(reg_addr)) else $error("pointer moved without cause"); // R5

    AST_START_RELEASE: assert property (@(posedge clk) disable iff (rst)
        start_evt |=> !sda_oe) else $error("SDA held after START"); // R10

    AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (rst)
        stop_evt |=> !sda_oe) else $error("SDA held after STOP"); // R10
endmodule

bind i2c_word_slave i2c_word_slave_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .sda_oe    (sda_oe),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .start_evt (line_start),
    .stop_evt  (line_stop),
    .ptr_load  (eng_ptr_load),
    .ptr_step  (eng_ptr_step)
);

// File: tb/i2c_word_slave_test.sv
module i2c_word_slave_test;
    localparam int H = 12;
    localparam logic [5:0] SEL   = 6'b010110;
    localparam logic [7:0] DEV_W = 8'hAC;
    localparam logic [7:0] DEV_R = 8'hAD;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic        sda_oe;
    logic        sda_line;
    logic [7:0]  reg_addr;
    logic [15:0] reg_wdata;
    logic        reg_we;
    logic [15:0] reg_rdata;
    logic [15:0] regs [256];
    logic [15:0] rd_buf [4];
    int we_cnt = 0;
    int oe_cnt = 0;
    int total = 0;
    int fails = 0;
    bit done = 0;

    assign sda_line  = sda_m & ~sda_oe;
    assign reg_rdata = regs[reg_addr];

    i2c_word_slave uut (
        .clk       (clk),
        .rst       (rst),
        .scl_i     (scl_m),
        .sda_i     (sda_line),
        .sda_oe    (sda_oe),
        .dev_sel   (SEL),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_we    (reg_we),
        .reg_rdata (reg_rdata)
    );

    function automatic logic [15:0] init_val(input logic [7:0] a);
        return {a, ~a};
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 256; i++) regs[i] <= init_val(8'(i));
        end else if (reg_we) begin
            regs[reg_addr] <= reg_wdata;
            we_cnt <= we_cnt + 1;
        end
        if (sda_oe) oe_cnt <= oe_cnt + 1;
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(H);
        scl_m = 1'b1; tick(H);
        sda_m = 1'b0; tick(H);
        scl_m = 1'b0; tick(H);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(H);
        scl_m = 1'b1; tick(H);
        sda_m = 1'b1; tick(H);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; tick(H);
            scl_m = 1'b1; tick(H);
            scl_m = 1'b0; tick(2);
        end
        sda_m = 1'b1; tick(H);
        scl_m = 1'b1; tick(H/2);
        ack = ~sda_line; tick(H/2);
        scl_m = 1'b0; tick(2);
    endtask

    task automatic recv_byte(output logic [7:0] b, input logic ack);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            tick(H);
            scl_m = 1'b1; tick(H/2);
            b[i] = sda_line; tick(H/2);
            scl_m = 1'b0;
        end
        tick(2);
        sda_m = ~ack; tick(H);
        scl_m = 1'b1; tick(H);
        scl_m = 1'b0; tick(2);
        sda_m = 1'b1;
    endtask

    task automatic read_words(input int n);
        logic [7:0] h, l;
        for (int w = 0; w < n; w++) begin
            recv_byte(h, 1'b1);
            recv_byte(l, w != n - 1);
            rd_buf[w] = {h, l};
        end
    endtask

    task automatic write_word(input logic [7:0] p, input logic [15:0] d, output logic [3:0] acks);
        bus_start();
        send_byte(DEV_W, acks[3]);
        send_byte(p, acks[2]);
        send_byte(d[15:8], acks[1]);
        send_byte(d[7:0], acks[0]);
        bus_stop();
        tick(4);
    endtask

    task automatic random_read(input logic [7:0] p, input int n);
        logic a;
        bus_start();
        send_byte(DEV_W, a);
        send_byte(p, a);
        bus_start();
        send_byte(DEV_R, a);
        read_words(n);
        bus_stop();
        tick(4);
    endtask

    task automatic current_read(input int n, output logic ack);
        bus_start();
        send_byte(DEV_R, ack);
        read_words(n);
        bus_stop();
        tick(4);
    endtask

    task automatic t_reset();
        rst = 1'b1; tick(5);
        rst = 1'b0; tick(2);
        check(reg_addr == 8'h00, "R2 pointer", 32'(reg_addr), 32'h0);
        check(!sda_oe, "R2 sda_oe", 32'(sda_oe), 32'h0);
        check(!reg_we, "R2 reg_we", 32'(reg_we), 32'h0);
    endtask

    task automatic t_read_after_reset();
        logic a;
        current_read(1, a);
        check(a, "R1 device ack", 32'(a), 32'h1);
        check(rd_buf[0] == init_val(8'h00), "R6 read reg 0", 32'(rd_buf[0]), 32'(init_val(8'h00)));
        check(reg_addr == 8'h01, "R5 step after read word", 32'(reg_addr), 32'h1);
    endtask

    task automatic t_write();
        logic [3:0] acks;
        int w0 = we_cnt;
        write_word(8'h12, 16'hA5C3, acks);
        check(acks == 4'hF, "R3 four acks", 32'(acks), 32'hF);
        check(we_cnt - w0 == 1, "R3 one strobe", 32'(we_cnt - w0), 32'h1);
        check(regs[8'h12] == 16'hA5C3, "R3 register written", 32'(regs[8'h12]), 32'hA5C3);
        check(reg_addr == 8'h13, "R5 step after write", 32'(reg_addr), 32'h13);
    endtask

    task automatic t_random();
        int w0 = we_cnt;
        random_read(8'h12, 1);
        check(rd_buf[0] == 16'hA5C3, "R7 random read data", 32'(rd_buf[0]), 32'hA5C3);
        check(we_cnt == w0, "R7 no strobe", 32'(we_cnt - w0), 32'h0);
        check(reg_addr == 8'h13, "R5 pointer after random read", 32'(reg_addr), 32'h13);
    endtask

    task automatic t_current();
        logic a;
        current_read(1, a);
        check(rd_buf[0] == init_val(8'h13), "R6 current read", 32'(rd_buf[0]), 32'(init_val(8'h13)));
    endtask

    task automatic t_stream();
        random_read(8'h20, 3);
        for (int w = 0; w < 3; w++)
            check(rd_buf[w] == init_val(8'(8'h20 + w)), "R9 streamed word", 32'(rd_buf[w]), 32'(init_val(8'(8'h20 + w))));
        check(reg_addr == 8'h23, "R5 pointer after stream", 32'(reg_addr), 32'h23);
    endtask

    task automatic t_msb_nack();
        logic a;
        logic [7:0] h;
        bus_start();
        send_byte(DEV_W, a);
        send_byte(8'h30, a);
        bus_start();
        send_byte(DEV_R, a);
        recv_byte(h, 1'b0);
        bus_stop();
        tick(4);
        check(h == init_val(8'h30)[15:8], "R8 high byte first", 32'(h), 32'(init_val(8'h30)[15:8]));
        check(reg_addr == 8'h30, "R8 pointer kept", 32'(reg_addr), 32'h30);
        check(!sda_oe, "R10 released after stop", 32'(sda_oe), 32'h0);
    endtask

    task automatic t_wrong_addr();
        logic a;
        int o0 = oe_cnt;
        int w0 = we_cnt;
        bus_start();
        send_byte(8'hAE, a);
        check(!a, "R1 other address no ack", 32'(a), 32'h0);
        send_byte(8'h55, a);
        send_byte(8'h11, a);
        send_byte(8'h22, a);
        bus_stop();
        tick(4);
        check(oe_cnt == o0, "R1 SDA untouched", 32'(oe_cnt - o0), 32'h0);
        check(we_cnt == w0, "R1 no strobe", 32'(we_cnt - w0), 32'h0);
        check(reg_addr == 8'h30, "R1 pointer kept", 32'(reg_addr), 32'h30);
        bus_start();
        send_byte(8'h2C, a);
        bus_stop();
        tick(4);
        check(!a, "R1 top bit clear no ack", 32'(a), 32'h0);
    endtask

    task automatic t_cut_write();
        logic a, r;
        int w0 = we_cnt;
        bus_start();
        send_byte(DEV_W, a);
        send_byte(8'h40, a);
        send_byte(8'hAA, a);
        bus_stop();
        tick(4);
        check(we_cnt == w0, "R4 no strobe", 32'(we_cnt - w0), 32'h0);
        check(reg_addr == 8'h40, "R4 pointer loaded", 32'(reg_addr), 32'h40);
        current_read(1, r);
        check(rd_buf[0] == init_val(8'h40), "R4 register unchanged", 32'(rd_buf[0]), 32'(init_val(8'h40)));
    endtask

    task automatic t_restart_write();
        logic a;
        int w0 = we_cnt;
        bus_start();
        send_byte(DEV_W, a);
        send_byte(8'h50, a);
        send_byte(8'h11, a);
        bus_start();
        send_byte(DEV_W, a);
        send_byte(8'h51, a);
        send_byte(8'hBE, a);
        send_byte(8'hEF, a);
        bus_stop();
        tick(4);
        check(we_cnt - w0 == 1, "R10 one strobe after restart", 32'(we_cnt - w0), 32'h1);
        check(regs[8'h51] == 16'hBEEF, "R10 second write done", 32'(regs[8'h51]), 32'hBEEF);
        random_read(8'h50, 1);
        check(rd_buf[0] == init_val(8'h50), "R10 partial word dropped", 32'(rd_buf[0]), 32'(init_val(8'h50)));
    endtask

    task automatic t_wrap();
        logic [3:0] acks;
        logic a;
        write_word(8'hFF, 16'h1234, acks);
        check(reg_addr == 8'h00, "R11 pointer wraps", 32'(reg_addr), 32'h0);
        check(regs[8'hFF] == 16'h1234, "R11 top register written", 32'(regs[8'hFF]), 32'h1234);
        current_read(1, a);
        check(rd_buf[0] == init_val(8'h00), "R11 read after wrap", 32'(rd_buf[0]), 32'(init_val(8'h00)));
    endtask

    initial begin
        t_reset();
        t_read_after_reset();
        t_write();
        t_random();
        t_current();
        t_stream();
        t_msb_nack();
        t_wrong_addr();
        t_cut_write();
        t_restart_write();
        t_wrap();
        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end
endmodule